// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a single-channel SPI master. Each word it takes from a ready/valid transmit input is shifted out on the MOSI line. At the same time the MISO line is sampled into a receive word, and that word is handed to a ready/valid receive output. The engine drives the serial clock and one frame-select line. While transmit words keep arriving it runs them back to back inside one frame. When the queue runs dry, or when the enable input is dropped, it closes the frame.

The serial timing comes from four independent static controls rather than a two-bit mode number:
- the sampling edge;
- the clock level between frames;
- an optional lead delay before the first clock edge;
- the frame-start edge, which sets the length of that delay.

The other static controls are:
- an 8-bit even divide ratio (4 to 254), with one serial-clock half period lasting ratio/2 system clocks;
- the active level of frame select;
- a 6-bit word length (1 to 32 bits; a value of 0 or above 32 is treated as 32);
- a bit-order select.

Configuration inputs may only change while no frame is open.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, sclk sits at the level given by idleHigh, frameSel is at its inactive level, rxValid is 0, and txReady equals enable.
- R2: Consecutive sclk edges within a word are exactly divRatio/2 system clocks apart, and every word produces exactly 2*len sclk edges.
- R3: Whenever frameSel is inactive, sclk equals idleHigh (0 = low, 1 = high). The first edge of every word moves sclk away from that level.
- R4: MISO is sampled on capture edges: rising edges when captureFall=0, falling edges when captureFall=1. The first data bit is on mosi from the start of the word. MOSI changes only on a non-capture edge that follows a capture, so it is stable at every capture edge.
- R5: The first sclk edge of a frame comes L half periods after frameSel turns active. L = 1 with clkDelay=0, L = 3 (one full period of delay) with clkDelay=1 and startFall=0, and L = 2 (half a period of delay) with clkDelay=1 and startFall=1.
- R6: frameSel is high while active when fsActiveHigh=1 and low while active when fsActiveHigh=0. Its inactive level is the opposite.
- R7: Exactly len bits are exchanged per word. The received word is right-aligned in rxData, with bits len..31 equal to 0.
- R8: With lsbFirst=0, bit len-1 of the word is sent first and bit 0 last. With lsbFirst=1, bit 0 is sent first. The k-th received bit lands at the same position as the k-th sent bit.
- R9: Words accepted back to back share one frame: frameSel stays active between them. frameSel goes inactive only after the last edge of the last word, and sclk makes no edge while frameSel is inactive.
- R10: When enable is 0, the word in progress completes and is delivered, the frame then closes, txReady stays 0, and sclk rests at its idle level.
- R11: While rxValid is 1 and rxReady is 0, rxData holds its value. A following finished word waits with the frame still open until the output is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; stops at a word boundary when low |
| divRatio | input | 8 | Even divide ratio, 4 to 254 |
| captureFall | input | 1 | 0: sample on rising sclk, 1: on falling |
| idleHigh | input | 1 | sclk level between frames |
| clkDelay | input | 1 | Adds a lead delay before the first edge |
| startFall | input | 1 | Frame-start edge; selects half-period (1) or full-period (0) delay |
| fsActiveHigh | input | 1 | Active level of frameSel |
| wordLen | input | 6 | Bits per word, 1 to 32 |
| lsbFirst | input | 1 | 1: least significant bit first |
| txData | input | 32 | Word to transmit |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Engine accepts txData this cycle |
| rxData | output | 32 | Received word, right-aligned |
| rxValid | output | 1 | rxData is valid |
| rxReady | input | 1 | Consumer takes rxData this cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frameSel | output | 1 | Frame-select line |

## Verification
The bench sweeps every combination of the four timing controls, two divide ratios, word lengths of 1, 7 and 32, both bit orders and alternating polarity. A small slave model checks the waveform: it measures lead time and edge spacing, and exchanges independent words in both directions. These checks would catch a design that shifts MOSI on the capture edge, or one that advances on the first edge when capture is the second edge; either one corrupts or rotates the words. A wrong lead count shows up as a mis-timed first edge, and a 1-bit or 32-bit word exposes off-by-one index or mask errors. Separate runs drop enable mid-stream, which catches a design that truncates the word or keeps pulling data. They also stall the receive side, which catches a design that overwrites the held word or closes the frame early.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Sequencer states of the engine.
  typedef enum logic [2:0] {
    ST_IDLE,   // no frame open
    ST_LEAD,   // frame open, waiting for the first edge of a word
    ST_BITS,   // toggling sclk
    ST_DONE,   // word finished, waiting to hand it over
    ST_TAIL    // last half period before the frame closes
  } engState_t;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic load;     // take a new transmit word
    logic capture;  // sample miso into the receive word
    logic shift;    // non-capture edge: move to the next bit if due
    logic push;     // hand the receive word to the output
  } engStrobe_t;

endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             captureFall,
  input  logic             idleHigh,
  input  logic             clkDelay,
  input  logic             startFall,
  input  logic [LEN_W-1:0] lenEff,
  input  logic             txValid,
  input  logic             rxFree,
  output logic             txReady,
  output engStrobe_t       stb,
  output logic             sclkOut,
  output logic             fsActive
);

  localparam int HALF_W = DIV_W - 1;
  localparam int EDGE_W = LEN_W + 1;

  engState_t         state;
  logic [HALF_W-1:0] halfLen;
  logic [HALF_W-1:0] hcnt;
  logic              tick;
  logic [1:0]        leadCnt;
  logic [1:0]        leadInit;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeTotal;
  logic              phase;
  logic              toggle;
  logic              newLevel;
  logic              capEdge;

  assign halfLen  = divRatio[DIV_W-1:1];
  assign tick     = (hcnt == halfLen - 1'b1);
  assign leadInit = clkDelay ? (startFall ? 2'd1 : 2'd2) : 2'd0;

  always_comb begin
    txReady  = enable && ((state == ST_IDLE) || ((state == ST_DONE) && rxFree));
    toggle   = tick && (((state == ST_LEAD) && (leadCnt == 2'd0)) ||
                        ((state == ST_BITS) && (edgeCnt != edgeTotal)));
    newLevel = (~phase) ^ idleHigh;
    capEdge  = newLevel ^ captureFall;
    stb.load    = txReady && txValid;
    stb.capture = toggle && capEdge;
    stb.shift   = toggle && !capEdge;
    stb.push    = (state == ST_DONE) && rxFree;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hcnt      <= '0;
      leadCnt   <= '0;
      edgeCnt   <= '0;
      edgeTotal <= '0;
      phase     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stb.load) begin
            state     <= ST_LEAD;
            hcnt      <= '0;
            leadCnt   <= leadInit;
            edgeTotal <= {lenEff, 1'b0};
            edgeCnt   <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            hcnt <= '0;
            if (leadCnt == 2'd0) begin
              state   <= ST_BITS;
              phase   <= ~phase;
              edgeCnt <= EDGE_W'(1);
            end else begin
              leadCnt <= leadCnt - 2'd1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (tick) begin
            hcnt <= '0;
            if (edgeCnt == edgeTotal) begin
              state <= ST_DONE;
            end else begin
              phase   <= ~phase;
              edgeCnt <= edgeCnt + 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (rxFree) begin
            hcnt <= '0;
            if (stb.load) begin
              state     <= ST_LEAD;
              leadCnt   <= leadInit;
              edgeTotal <= {lenEff, 1'b0};
              edgeCnt   <= '0;
            end else begin
              state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            hcnt  <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fsActive = (state != ST_IDLE);
  assign sclkOut  = phase ^ idleHigh;

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_BITS) |-> (phase == 1'b0));

  // R2
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS) |-> ((edgeCnt != '0) && (edgeCnt <= edgeTotal)));

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !enable) |=> (state == ST_IDLE));

endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        stb,
  input  logic              lsbFirst,
  input  logic [LEN_W-1:0]  lenEff,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  input  logic              rxReady,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFree
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] txWord;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxOut;
  logic              rxValidQ;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  firstIdx;
  logic              pending;
  logic              lsbQ;
  logic [LEN_W-1:0]  lenQ;

  assign firstIdx = lsbFirst ? '0 : IDX_W'(lenEff - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      rxShift <= '0;
      idx     <= '0;
      pending <= 1'b0;
      lsbQ    <= 1'b0;
      lenQ    <= '0;
    end else if (stb.load) begin
      txWord  <= txData;
      rxShift <= '0;
      idx     <= firstIdx;
      pending <= 1'b0;
      lsbQ    <= lsbFirst;
      lenQ    <= lenEff;
    end else begin
      if (stb.capture) begin
        rxShift[idx] <= miso;
        pending      <= 1'b1;
      end
      if (stb.shift && pending) begin
        idx     <= lsbQ ? idx + 1'b1 : idx - 1'b1;
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOut    <= '0;
      rxValidQ <= 1'b0;
    end else if (stb.push) begin
      rxOut    <= rxShift;
      rxValidQ <= 1'b1;
    end else if (rxReady) begin
      rxValidQ <= 1'b0;
    end
  end

  assign mosi    = txWord[idx];
  assign rxData  = rxOut;
  assign rxValid = rxValidQ;
  assign rxFree  = !rxValidQ || rxReady;

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R7
  rx_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> lenEff) == '0));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> ({1'b0, idx} < {1'b0, lenQ}));

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divRatio,
  input  logic              captureFall,
  input  logic              idleHigh,
  input  logic              clkDelay,
  input  logic              startFall,
  input  logic              fsActiveHigh,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              frameSel
);

  engStrobe_t       stb;
  logic             rxFree;
  logic             fsActive;
  logic [LEN_W-1:0] lenEff;

  assign lenEff = ((wordLen == '0) || (wordLen > LEN_W'(DATA_W))) ? LEN_W'(DATA_W) : wordLen;

  spi_eng_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .divRatio   (divRatio),
    .captureFall(captureFall),
    .idleHigh   (idleHigh),
    .clkDelay   (clkDelay),
    .startFall  (startFall),
    .lenEff     (lenEff),
    .txValid    (txValid),
    .rxFree     (rxFree),
    .txReady    (txReady),
    .stb        (stb),
    .sclkOut    (sclk),
    .fsActive   (fsActive)
  );

  spi_eng_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .lsbFirst(lsbFirst),
    .lenEff  (lenEff),
    .txData  (txData),
    .miso    (miso),
    .rxReady (rxReady),
    .mosi    (mosi),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxFree  (rxFree)
  );

  assign frameSel = ~(fsActive ^ fsActiveHigh);

  // R6
  fs_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fsActive) |-> (frameSel == !fsActiveHigh));

endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic [7:0]  divRatio = 8'd4;
  logic        captureFall = 1'b0;
  logic        idleHigh = 1'b0;
  logic        clkDelay = 1'b0;
  logic        startFall = 1'b0;
  logic        fsActiveHigh = 1'b0;
  logic [5:0]  wordLen = 6'd8;
  logic        lsbFirst = 1'b0;
  logic [31:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [31:0] rxData;
  logic        rxValid;
  logic        rxReady = 1'b1;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic        frameSel;
  logic        fsOn;

  always #5 clk = ~clk;

  spi_shift_master u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divRatio(divRatio),
    .captureFall(captureFall), .idleHigh(idleHigh), .clkDelay(clkDelay),
    .startFall(startFall), .fsActiveHigh(fsActiveHigh), .wordLen(wordLen),
    .lsbFirst(lsbFirst), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .sclk(sclk),
    .mosi(mosi), .miso(miso), .frameSel(frameSel)
  );

  assign fsOn = (frameSel == fsActiveHigh);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int l);
    if (l >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << l) - 32'd1;
  endfunction

  // Stimulus words and observed results of one run.
  logic [31:0] mw [0:3];
  logic [31:0] sw [0:3];
  logic [31:0] rxGot [0:3];
  logic [31:0] slvGot [0:3];
  int nWords = 0, lenCfg = 8, expH = 2, expL = 1;
  int rxCnt = 0, slvCnt = 0, frames = 0, idleErr = 0, strayErr = 0;
  logic [31:0] seed = 32'h1234_5678;

  // Slave model state.
  logic        prevSclk = 1'b0;
  logic        prevFs = 1'b0;
  int          edgeInWord = 0, capCnt = 0, sBit = 0, lastEdgeCyc = 0, fsCyc = 0;
  bit          pend = 0, firstInFrame = 0;
  logic [31:0] sAcc = '0;

  function automatic int bitPos(input int k);
    return lsbFirst ? k : lenCfg - 1 - k;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (fsOn && !prevFs) begin
        frames++;
        fsCyc = cyc; firstInFrame = 1;
        edgeInWord = 0; capCnt = 0; sAcc = '0; pend = 0; sBit = 0;
        if (slvCnt < 4) miso = sw[slvCnt][bitPos(0)];
      end
      if (!fsOn && sclk != idleHigh) idleErr++;
      if (!fsOn && prevFs == fsOn && sclk != prevSclk) strayErr++;
      if (fsOn && sclk != prevSclk) begin
        if (firstInFrame) begin
          chk(cyc - fsCyc == expL * expH, "R5 lead before first edge", cyc - fsCyc, expL * expH);
          firstInFrame = 0;
        end else if (edgeInWord > 0) begin
          chk(cyc - lastEdgeCyc == expH, "R2 edge spacing", cyc - lastEdgeCyc, expH);
        end
        if (edgeInWord == 0)
          chk(sclk != idleHigh, "R3 first edge leaves idle level", sclk, !idleHigh);
        lastEdgeCyc = cyc;
        edgeInWord++;
        if (sclk ^ captureFall) begin
          if (capCnt < 32) sAcc[bitPos(capCnt)] = mosi;
          capCnt++; pend = 1;
        end else if (pend && capCnt < lenCfg) begin
          sBit++; pend = 0;
          if (slvCnt < 4) miso = sw[slvCnt][bitPos(sBit)];
        end
        if (edgeInWord == 2 * lenCfg) begin
          if (slvCnt < 4) slvGot[slvCnt] = sAcc;
          slvCnt++;
          edgeInWord = 0; capCnt = 0; sAcc = '0; pend = 0; sBit = 0;
          if (slvCnt < nWords && slvCnt < 4) miso = sw[slvCnt][bitPos(0)];
        end
      end
      if (rxValid && rxReady) begin
        if (rxCnt < 4) rxGot[rxCnt] = rxData;
        rxCnt++;
      end
    end
    prevSclk = sclk;
    prevFs = fsOn;
  end

  task automatic runXfer(input int n, input int dropAt, input bit holdRx);
    int guard;
    bit acc;
    logic [31:0] d0;
    logic [31:0] m;
    rxCnt = 0; slvCnt = 0; frames = 0; idleErr = 0; strayErr = 0;
    nWords = n;
    lenCfg = int'(wordLen);
    expH = int'(divRatio) / 2;
    expL = clkDelay ? (startFall ? 2 : 3) : 1;
    m = maskOf(lenCfg);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223; mw[i] = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; sw[i] = seed;
    end
    if (holdRx) rxReady = 1'b0;
    for (int i = 0; i < n; i++) begin
      txData = mw[i]; txValid = 1'b1; acc = 0; guard = 0;
      while (!acc && guard < 20000) begin
        @(negedge clk); acc = txReady;
        @(posedge clk); #1; guard++;
      end
      if (!acc) chk(0, "R9 word accepted", 0, 1);
      if (i + 1 == dropAt) begin
        if (i + 1 < n) txData = mw[i + 1];
        repeat (5) @(posedge clk);
        #1 enable = 1'b0;
        guard = 0;
        while (fsOn && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk(rxCnt == i + 1, "R10 word in progress delivered", rxCnt, i + 1);
        chk(slvCnt == i + 1, "R10 word in progress completed", slvCnt, i + 1);
        repeat (40) @(negedge clk);
        chk(txReady == 1'b0, "R10 no word taken while disabled", txReady, 0);
        chk(!fsOn && sclk == idleHigh, "R10 engine parked", {fsOn, sclk}, {1'b0, idleHigh});
        chk(rxCnt == i + 1, "R10 nothing more received", rxCnt, i + 1);
        @(posedge clk); #1 enable = 1'b1;
      end
    end
    txValid = 1'b0;
    if (holdRx) begin
      repeat (200) @(negedge clk);
      chk(rxValid == 1'b1, "R11 output held", rxValid, 1);
      d0 = rxData;
      chk(d0 == (sw[0] & m), "R11 held word is the first", d0, sw[0] & m);
      chk(fsOn, "R11 frame kept open while output full", fsOn, 1);
      repeat (20) @(negedge clk);
      chk(rxData == d0, "R11 held data stable", rxData, d0);
      @(posedge clk); #1 rxReady = 1'b1;
    end
    guard = 0;
    while (!(rxCnt == n && !fsOn) && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(rxCnt == n, "R9 all words received", rxCnt, n);
    chk(slvCnt == n, "R2 edge count per word", slvCnt, n);
    for (int i = 0; i < n && i < 4; i++) begin
      chk(rxGot[i] == (sw[i] & m), "R4 R8 received word", rxGot[i], sw[i] & m);
      chk((rxGot[i] & ~m) == 32'd0, "R7 upper bits zero", rxGot[i] & ~m, 0);
      chk(slvGot[i] == (mw[i] & m), "R8 transmitted word", slvGot[i], mw[i] & m);
    end
    chk(frames == ((dropAt > 0) ? 2 : 1), "R9 frame count", frames, (dropAt > 0) ? 2 : 1);
    chk(idleErr == 0, "R3 sclk idle while frame inactive", idleErr, 0);
    chk(strayErr == 0, "R9 no edge outside frame", strayErr, 0);
    chk(frameSel == !fsActiveHigh, "R6 inactive level after frame", frameSel, !fsActiveHigh);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(sclk == idleHigh, "R1 sclk idle after reset", sclk, idleHigh);
    chk(frameSel == !fsActiveHigh, "R1 frameSel inactive after reset", frameSel, !fsActiveHigh);
    chk(rxValid == 1'b0, "R1 rxValid low after reset", rxValid, 0);
    chk(txReady == enable, "R1 txReady follows enable", txReady, enable);

    for (int d = 4; d <= 6; d += 2) begin
      for (int t = 0; t < 16; t++) begin
        for (int li = 0; li < 3; li++) begin
          for (int lb = 0; lb < 2; lb++) begin
            @(posedge clk); #1;
            divRatio     = 8'(d);
            captureFall  = t[0];
            idleHigh     = t[1];
            clkDelay     = t[2];
            startFall    = t[3];
            wordLen      = (li == 0) ? 6'd1 : ((li == 1) ? 6'd7 : 6'd32);
            lsbFirst     = lb[0];
            fsActiveHigh = t[0] ^ t[1] ^ li[0] ^ lb[0];
            repeat (2) @(posedge clk); #1;
            runXfer(2, 0, 0);
          end
        end
      end
    end

    // Enable dropped during the second of three words.
    @(posedge clk); #1;
    divRatio = 8'd4; captureFall = 1'b1; idleHigh = 1'b0; clkDelay = 1'b1;
    startFall = 1'b0; wordLen = 6'd8; lsbFirst = 1'b0; fsActiveHigh = 1'b0;
    repeat (2) @(posedge clk); #1;
    runXfer(3, 2, 0);

    // Receive side stalled across two words.
    @(posedge clk); #1;
    divRatio = 8'd6; captureFall = 1'b0; idleHigh = 1'b1; clkDelay = 1'b0;
    startFall = 1'b1; wordLen = 6'd12; lsbFirst = 1'b1; fsActiveHigh = 1'b1;
    repeat (2) @(posedge clk); #1;
    runXfer(2, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule